// File: doc/BRIEF.md
# MDIO Management Master

This block runs register reads and writes to an Ethernet PHY over the two-wire management bus. A host places a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data on its inputs, then pulses `start`. The block produces the management clock and drives or releases the data line, and it frames each transaction bit by bit. At the end it pulses `done` together with the read data and an error flag. The bidirectional data pin is split into `mdio_o`, `mdio_oe` and `mdio_i`. The pad is outside the block.

The management clock is derived from the system clock. Each half-period lasts `DIV` system clocks. The default of 200 gives a 1 µs half-period with a 200 MHz clock. On a read, the block checks that the PHY pulls the turnaround bit low. If the PHY does not, the block spends a burst of idle clocks to let the PHY resynchronise, and then reports the error.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, `mdc` is 1, `mdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Every transaction opens with 32 MDC cycles in which the data line is driven (`mdio_oe`=1) at 1.
- R3: Bit cycles 32 to 35 are driven and carry the start pattern 0,1 followed by the opcode. The opcode is 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (`rd_nwr`=0).
- R4: Bit cycles 36 to 40 carry `phy_addr` and bit cycles 41 to 45 carry `reg_addr`, each most significant bit first and driven.
- R5: Each MDC low phase and each high phase lasts exactly `DIV` system clocks. `mdio_o` and `mdio_oe` change only in the clock where MDC falls, so every bit is stable for its whole cycle.
- R6: On a read, the data line is released from bit cycle 46 onward. If `mdio_i` is 1 in the first clock of the high phase of cycle 46, the block issues 32 more released cycles (79 in total). It then pulses `done` with `err`=1 and `rdata`=0.
- R7: On a read whose turnaround sample is 0, the block takes 16 data bits from bit cycles 47 to 62, MSB first. Each bit is sampled in the first clock of the MDC high phase. Two more released cycles follow (65 in total), then `done` with `err`=0 and the captured `rdata`.
- R8: On a write, the block drives the turnaround as 1 then 0 (cycles 46 and 47). It then drives `wdata` MSB first in cycles 48 to 63 and releases the line for one final cycle 64 (65 in total). `done` comes with `err`=0.
- R9: `busy` is 1 from the clock after `start` is taken until `done`. `done` is a one-clock pulse in the clock where `busy` falls.
- R10: A `start` pulse while `busy` is 1 is ignored. The frame in progress keeps its original fields and exactly one `done` results.
- R11: `err` and `rdata` hold their values after `done`. A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data for a write |
| rdata | output | 16 | Data of the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-transaction pulse |
| err | output | 1 | Last read saw no turnaround response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench models a PHY that pulls the turnaround low or leaves it high on command, and that answers with chosen data. It records the line state at every MDC rise and compares the preamble, header and tail against frames it builds itself. A block that sampled the turnaround on the wrong edge, miscounted the recovery burst or left out the trailing cycles would show a wrong cycle count or a wrong `err` value. A bit order off by one would corrupt addresses or data. A prescaler with an off-by-one count would break the half-period measurement. The bench also fires a second start in the middle of a frame, and a block that latched it would change the header or produce two `done` pulses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned PRE_BITS = 32;
  // start pair + opcode pair + two address fields
  localparam int unsigned HDR_BITS = 4 + 2 * ADDR_W;
  localparam int unsigned IDX_TA   = PRE_BITS + HDR_BITS;
  localparam int unsigned IDX_LAST = IDX_TA + 2 + DATA_W;
  localparam int unsigned IDX_LAST_ERR = IDX_TA + PRE_BITS;
  localparam int unsigned IDX_W    = $clog2(IDX_LAST_ERR + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int unsigned DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick,
  output logic first
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick  = run && (cnt_q == CNT_MAX);
  assign first = (cnt_q == '0);
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  mdio_req_t        req,
  output logic             bit_o,
  output logic             bit_oe
);
  localparam logic [IDX_W-1:0] I_START = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] I_OP    = IDX_W'(PRE_BITS + 2);
  localparam logic [IDX_W-1:0] I_PHY   = IDX_W'(PRE_BITS + 4);
  localparam logic [IDX_W-1:0] I_REG   = IDX_W'(PRE_BITS + 4 + ADDR_W);
  localparam logic [IDX_W-1:0] I_TA    = IDX_W'(IDX_TA);
  localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(IDX_LAST);

  logic [IDX_W-1:0] off;

  always_comb begin
    bit_o  = 1'b1;
    bit_oe = 1'b1;
    off    = '0;
    if (idx < I_START) begin
      bit_o = 1'b1;
    end else if (idx < I_OP) begin
      bit_o = (idx == I_START + 1'b1);
    end else if (idx < I_PHY) begin
      bit_o = req.rd ? (idx == I_OP) : (idx == I_OP + 1'b1);
    end else if (idx < I_REG) begin
      off   = I_REG - 1'b1 - idx;
      bit_o = req.phy[off[2:0]];
    end else if (idx < I_TA) begin
      off   = I_TA - 1'b1 - idx;
      bit_o = req.regad[off[2:0]];
    end else if (req.rd) begin
      bit_o  = 1'b0;
      bit_oe = 1'b0;
    end else if (idx == I_TA) begin
      bit_o = 1'b1;
    end else if (idx == I_TA + 1'b1) begin
      bit_o = 1'b0;
    end else if (idx < I_LAST) begin
      off   = I_LAST - 1'b1 - idx;
      bit_o = req.wdata[off[3:0]];
    end else begin
      bit_o  = 1'b0;
      bit_oe = 1'b0;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_req_t         req_in,
  input  logic              tick,
  input  logic              first,
  input  logic              mdio_i,
  input  logic              fr_o,
  input  logic              fr_oe,
  output logic [IDX_W-1:0]  idx_nxt,
  output mdio_req_t         req_cur,
  output logic              run,
  output logic              clear,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] I_TA   = IDX_W'(IDX_TA);
  localparam logic [IDX_W-1:0] I_DEND = IDX_W'(IDX_TA + DATA_W);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(IDX_LAST);
  localparam logic [IDX_W-1:0] I_LERR = IDX_W'(IDX_LAST_ERR);

  eng_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              mdc_q, mdc_d;
  logic              o_q, o_d;
  logic              oe_q, oe_d;
  mdio_req_t         req_q, req_d;
  logic              recov_q, recov_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              done_q, done_d;

  logic at_ta, in_data, at_last;

  assign idx_nxt = idx_q + 1'b1;
  assign at_ta   = (idx_q == I_TA);
  assign in_data = (idx_q > I_TA) && (idx_q <= I_DEND);
  assign at_last = recov_q ? (idx_q == I_LERR) : (idx_q == I_LAST);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mdc_d   = mdc_q;
    o_d     = o_q;
    oe_d    = oe_q;
    req_d   = req_q;
    recov_d = recov_q;
    shreg_d = shreg_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    done_d  = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOW;
          req_d   = req_in;
          idx_d   = '0;
          recov_d = 1'b0;
          err_d   = 1'b0;
          mdc_d   = 1'b0;
          o_d     = 1'b1;
          oe_d    = 1'b1;
          clear   = 1'b1;
        end
      end
      ST_LOW: begin
        if (tick) begin
          state_d = ST_HIGH;
          mdc_d   = 1'b1;
        end
      end
      ST_HIGH: begin
        if (first && req_q.rd && !recov_q) begin
          if (at_ta && mdio_i) recov_d = 1'b1;
          if (in_data)         shreg_d = {shreg_q[DATA_W-2:0], mdio_i};
        end
        if (tick) begin
          if (at_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = req_q.rd & recov_q;
            if (req_q.rd) rdata_d = recov_q ? '0 : shreg_q;
          end else begin
            state_d = ST_LOW;
            mdc_d   = 1'b0;
            idx_d   = idx_nxt;
            o_d     = fr_o;
            oe_d    = fr_oe;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mdc_q   <= 1'b1;
      o_q     <= 1'b0;
      oe_q    <= 1'b0;
      req_q   <= '0;
      recov_q <= 1'b0;
      shreg_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      mdc_q   <= mdc_d;
      o_q     <= o_d;
      oe_q    <= oe_d;
      req_q   <= req_d;
      recov_q <= recov_d;
      shreg_q <= shreg_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign req_cur = req_q;
  assign run     = (state_q != ST_IDLE);
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mdc_q && !oe_q)); // R1
  AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> ($stable(o_q) && $stable(oe_q))); // R5
  AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q.rd && (state_q != ST_IDLE) && (idx_q >= I_TA)) |-> !oe_q); // R6
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (rdata_q == '0)); // R6
  AST_WR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !req_q.rd) |-> !err_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE)); // R9
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && $past(state_q != ST_IDLE)) |-> $stable(req_q)); // R10
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             tick, first, run, clear;
  logic             fr_o, fr_oe;
  logic [IDX_W-1:0] idx_nxt;
  mdio_req_t        req_in, req_cur;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign req_in = '{rd: rd_nwr, phy: phy_addr, regad: reg_addr, wdata: wdata};

  mdio_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (run),
    .clear (clear),
    .tick  (tick),
    .first (first)
  );

  mdio_framer u_framer (
    .idx    (idx_nxt),
    .req    (req_cur),
    .bit_o  (fr_o),
    .bit_oe (fr_oe)
  );

  mdio_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .req_in  (req_in),
    .tick    (tick),
    .first   (first),
    .mdio_i  (mdio_i),
    .fr_o    (fr_o),
    .fr_oe   (fr_oe),
    .idx_nxt (idx_nxt),
    .req_cur (req_cur),
    .run     (run),
    .clear   (clear),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rdata   (rdata)
  );
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int TB_DIV = 3;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, done, err, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // PHY model / monitor state
  bit phy_rd = 1'b0;
  bit phy_ta = 1'b0;
  logic [15:0] phy_data = '0;
  int rise_cnt = 0;
  int ph_err = 0;
  int stab_err = 0;
  int run_len = 0;
  logic prev_mdc = 1'b1;
  logic prev_busy = 1'b0;
  logic [1:0] prev_line = 2'b00;
  logic [127:0] obs_o, obs_oe;
  logic [15:0] model_rdata = '0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV(TB_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rise_cnt = 0; ph_err = 0; stab_err = 0; run_len = 1;
      end else if (mdc == prev_mdc) begin
        run_len++;
      end else begin
        if (mdc && run_len != TB_DIV) ph_err++;
        if (!mdc && rise_cnt > 0 && run_len != TB_DIV) ph_err++;
        run_len = 1;
      end
      if (mdc && !prev_mdc) begin
        if (rise_cnt < 128) begin
          obs_o[rise_cnt]  = mdio_o;
          obs_oe[rise_cnt] = mdio_oe;
        end
        rise_cnt++;
      end
      if (!mdc && prev_mdc) begin
        if (phy_rd && rise_cnt == 46)                      mdio_i = phy_ta;
        else if (phy_rd && rise_cnt >= 47 && rise_cnt <= 62) mdio_i = phy_data[62 - rise_cnt];
        else                                               mdio_i = 1'b1;
      end
      if ({mdio_oe, mdio_o} != prev_line && !(prev_mdc && !mdc)) stab_err++;
    end
    prev_mdc  = mdc;
    prev_busy = busy;
    prev_line = {mdio_oe, mdio_o};
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected {oe, o} of bit cycle i
  function automatic logic [1:0] exp_bit(int i, bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    logic [13:0] hdr;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    if (i < 32) return 2'b11;
    if (i < 46) return {1'b1, hdr[45 - i]};
    if (rd) return 2'b00;
    if (i == 46) return 2'b11;
    if (i == 47) return 2'b10;
    if (i < 64) return {1'b1, wd[63 - i]};
    return 2'b00;
  endfunction

  function automatic int region_bad(int lo, int hi, bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    int bad = 0;
    for (int i = lo; i < hi; i++) begin
      logic [1:0] e;
      e = exp_bit(i, rd, pa, ra, wd);
      if (obs_oe[i] !== e[1]) bad++;
      else if (e[1] && obs_o[i] !== e[0]) bad++;
    end
    return bad;
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit ta_bad, input logic [15:0] phy_val,
                         input bit poke);
    int n;
    int exp_n;
    bit exp_err;
    int dones;
    phy_rd = rd; phy_ta = ta_bad; phy_data = phy_val;
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (5 * TB_DIV) @(negedge clk);
      rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    exp_err = rd && ta_bad;
    exp_n   = exp_err ? 79 : 65;
    chk(done === 1'b1, "R9", "done reached", done, 1);
    chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
    chk(err === exp_err, rd ? (ta_bad ? "R6" : "R7") : "R8", "err at done", err, exp_err);
    chk(rise_cnt == exp_n, rd ? (ta_bad ? "R6" : "R7") : "R8", "MDC cycle count", rise_cnt, exp_n);
    chk(region_bad(0, 32, rd, pa, ra, wd) == 0, "R2", "preamble bits", region_bad(0, 32, rd, pa, ra, wd), 0);
    chk(region_bad(32, 36, rd, pa, ra, wd) == 0, poke ? "R10" : "R3", "start/opcode bits", region_bad(32, 36, rd, pa, ra, wd), 0);
    chk(region_bad(36, 46, rd, pa, ra, wd) == 0, poke ? "R10" : "R4", "address bits", region_bad(36, 46, rd, pa, ra, wd), 0);
    chk(region_bad(46, exp_n, rd, pa, ra, wd) == 0, rd ? "R6" : "R8", "tail bits", region_bad(46, exp_n, rd, pa, ra, wd), 0);
    chk(ph_err == 0, "R5", "half-period length errors", ph_err, 0);
    chk(stab_err == 0, "R5", "line changes outside MDC fall", stab_err, 0);
    if (rd) model_rdata = ta_bad ? 16'h0000 : phy_val;
    chk(rdata === model_rdata, rd ? (ta_bad ? "R6" : "R7") : "R11", "rdata at done", rdata, model_rdata);
    @(negedge clk);
    chk(done === 1'b0 && mdc === 1'b1 && mdio_oe === 1'b0, "R1", "idle line after done",
        {done, mdc, mdio_oe}, 3'b010);
    chk(err === exp_err && rdata === model_rdata, "R11", "err/rdata held", {err, rdata}, {exp_err, model_rdata});
    if (poke) begin
      dones = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done === 1'b1 || busy === 1'b1) dones++;
      end
      chk(dones == 0, "R10", "no second transaction", dones, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mdc === 1'b1 && mdio_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "reset state",
        {mdc, mdio_oe, busy, done}, 4'b1000);

    run_txn(1'b1, 5'h1F, 5'h00, 16'h0000, 1'b0, 16'hA5C3, 1'b0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h8001, 1'b0, 16'h0000, 1'b0);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b1, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'h03, 5'h11, 16'h0000, 1'b0, 16'h0001, 1'b0);
    run_txn(1'b0, 5'h15, 5'h0A, 16'h7FFE, 1'b0, 16'h0000, 1'b0);
    run_txn(1'b1, 5'h11, 5'h02, 16'h0000, 1'b0, 16'h8000, 1'b1);
    run_txn(1'b0, 5'h04, 5'h08, 16'h1234, 1'b0, 16'h0000, 1'b1);

    for (int t = 0; t < 16; t++) begin
      bit rd;
      rd = 1'($urandom % 2);
      run_txn(rd, 5'($urandom), 5'($urandom), 16'($urandom),
              rd && (($urandom % 6) == 0), 16'($urandom), 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule